// File: doc/BRIEF.md
# Buzzer tone generator

This block produces a 50% duty square wave for driving a piezo or magnetic buzzer. A single configuration word selects a prescale ratio for the system clock and a 6-bit match value. The prescaled tick advances a 6-bit counter. When the counter reaches the match value, the output phase flips and the count starts again from zero. The tone frequency is fsys / (2 × prescale × (match + 1)). With a 4 MHz system clock and the default prescale set of 8, 16, 32 and 64, the range runs from 250 kHz (prescale 8, match 0) down to about 488 Hz (prescale 64, match 63).

Software sets a new tone by writing the configuration word. Every write restarts the tone from a known state. A separate enable pin gates the output without stopping the count, so the tone can be muted and unmuted while keeping its phase. Pin multiplexing and the analog drive stage are outside this block. The configuration write is a single-cycle strobe and has no back-pressure: a write is accepted on every clock edge at which `cfg_wr` is high.

Top module: `buzz_tone_gen`

## Requirements
- R1: While reset is asserted and after reset is released, `buzz_out` is low and the configuration word is cleared. The cleared word selects the smallest prescale and match 0.
- R2: The configuration word carries the prescale select in bits [7:6] and the match value in bits [5:0]. Select value s divides the clock by 2^(PRE_BASE_LOG2+s), which is 8, 16, 32 or 64 by default.
- R3: The counter advances exactly once per prescaled tick. It never exceeds the match value and returns to zero on the tick after it equals the match value.
- R4: With the output enabled, each high phase and each low phase of `buzz_out` lasts exactly prescale × (match + 1) clock cycles.
- R5: A write clears the prescaler, the counter and the output phase at that clock edge. `buzz_out` is low after the write edge and first rises exactly one half period later, even when the write arrives in the middle of a high phase.
- R6: While `out_en` is low, `buzz_out` stays low and counting continues. When `out_en` rises again, the output shows the phase it would have had with no muting, and the next toggle keeps the original schedule.
- R7: Match value 0 gives the shortest half period, equal to the prescale ratio. Match value 63 gives the longest half period, equal to 64 × the prescale ratio.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_wr | input | 1 | Configuration write strobe, one cycle per write |
| cfg_data | input | 8 | Configuration word: [7:6] prescale select, [5:0] match value |
| out_en | input | 1 | Output enable; low forces the pin low |
| buzz_out | output | 1 | Square-wave tone output |

## Verification
The bench builds the block with PRE_BASE_LOG2 = 1. The four prescale ratios then become 2, 4, 8 and 16, and the slowest tone shrinks by a factor of four. At this size the bench can measure every one of the 64 match values under the two smallest ratios, cycle by cycle, and can cover both ends of the match range under the two larger ratios. The counter width and the field layout are the same as in the default build, so restart, muting and match-boundary behaviour are exercised exactly as the default build would see them.

// File: rtl/buzz_pkg.sv
package buzz_pkg;
  // Log2 of the clock division applied for a given prescale select.
  function automatic int unsigned buzz_div_log2(input int unsigned base_log2,
                                                input int unsigned sel);
    return base_log2 + sel;
  endfunction
endpackage

// File: rtl/buzz_prescaler.sv
module buzz_prescaler #(
  parameter int SEL_W         = 2,
  parameter int PRE_BASE_LOG2 = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic [SEL_W-1:0] sel,
  output logic             tick
);
  localparam int NSEL  = 1 << SEL_W;
  localparam int PRE_W = buzz_pkg::buzz_div_log2(PRE_BASE_LOG2, NSEL - 1);

  logic [PRE_W-1:0] pre_q;
  logic [PRE_W-1:0] term [NSEL];

  // Terminal count for each select: 2^(base+g) - 1
  for (genvar g = 0; g < NSEL; g++) begin : g_term
    localparam int SH = PRE_W - buzz_pkg::buzz_div_log2(PRE_BASE_LOG2, g);
    assign term[g] = {PRE_W{1'b1}} >> SH;
  end

  assign tick = !clr && (pre_q == term[sel]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          pre_q <= '0;
    else if (clr || tick) pre_q <= '0;
    else                 pre_q <= pre_q + 1'b1;
  end
endmodule

// File: rtl/buzz_tone_cnt.sv
module buzz_tone_cnt #(
  parameter int CNT_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             tick,
  input  logic [CNT_W-1:0] match,
  output logic [CNT_W-1:0] cnt_q,
  output logic             phase_q
);
  logic at_match;
  assign at_match = (cnt_q == match);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      phase_q <= 1'b0;
    end else if (clr) begin
      cnt_q   <= '0;
      phase_q <= 1'b0;
    end else if (tick) begin
      if (at_match) begin
        cnt_q   <= '0;
        phase_q <= ~phase_q;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/buzz_tone_gen.sv
module buzz_tone_gen #(
  parameter int CNT_W         = 6,
  parameter int SEL_W         = 2,
  parameter int PRE_BASE_LOG2 = 3
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   cfg_wr,
  input  logic [SEL_W+CNT_W-1:0] cfg_data,
  input  logic                   out_en,
  output logic                   buzz_out
);
  logic [SEL_W-1:0] sel_q;
  logic [CNT_W-1:0] match_q;
  logic             tick;
  logic [CNT_W-1:0] cnt_q;
  logic             phase_q;

  // Configuration register: select in the upper bits, match in the lower bits
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q   <= '0;
      match_q <= '0;
    end else if (cfg_wr) begin
      sel_q   <= cfg_data[SEL_W+CNT_W-1:CNT_W];
      match_q <= cfg_data[CNT_W-1:0];
    end
  end

  buzz_prescaler #(.SEL_W(SEL_W), .PRE_BASE_LOG2(PRE_BASE_LOG2)) u_pre (
    .clk(clk), .rst_n(rst_n), .clr(cfg_wr), .sel(sel_q), .tick(tick)
  );

  buzz_tone_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .clr(cfg_wr), .tick(tick),
    .match(match_q), .cnt_q(cnt_q), .phase_q(phase_q)
  );

  assign buzz_out = phase_q & out_en;
endmodule

// File: rtl/buzz_tone_chk.sv
module buzz_tone_chk #(
  parameter int CNT_W = 6
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cfg_wr,
  input logic             tick,
  input logic [CNT_W-1:0] cnt_q,
  input logic [CNT_W-1:0] match_q,
  input logic             phase_q
);
  p_cnt_within_match_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= match_q);

  p_hold_without_tick_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !cfg_wr) |=> ($stable(cnt_q) && $stable(phase_q)));

  p_clear_on_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_wr |=> (cnt_q == '0 && !phase_q));

  p_wrap_toggles_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !cfg_wr && cnt_q == match_q) |=> (phase_q != $past(phase_q) && cnt_q == '0));

  p_no_toggle_midcount_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !cfg_wr && cnt_q != match_q) |=> $stable(phase_q));
endmodule

bind buzz_tone_gen buzz_tone_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .tick(tick),
  .cnt_q(cnt_q), .match_q(match_q), .phase_q(phase_q)
);

// File: tb/test_buzz_tone_gen.sv
module test_buzz_tone_gen;
  localparam int BASE = 1;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_wr = 1'b0;
  logic [7:0] cfg_data = '0;
  logic       out_en = 1'b1;
  logic       buzz_out;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  buzz_tone_gen #(.CNT_W(6), .SEL_W(2), .PRE_BASE_LOG2(BASE)) i_buzz_tone_gen (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_data(cfg_data),
    .out_en(out_en), .buzz_out(buzz_out)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Write at one edge; return with the clock at the following negedge.
  task automatic wr_cfg(input int sel, input int match);
    @(negedge clk);
    cfg_data = 8'((sel << 6) | match);
    cfg_wr = 1'b1;
    @(posedge clk);
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  // Count edges until buzz_out reaches the level lvl.
  task automatic edges_to(input bit lvl, input int limit, output int n);
    n = 0;
    while (buzz_out !== lvl && n <= limit) begin
      @(posedge clk);
      @(negedge clk);
      n++;
    end
  endtask

  task automatic sweep_one(input int sel, input int match);
    int h, n;
    h = (1 << (BASE + sel)) * (match + 1);
    wr_cfg(sel, match);
    chk(buzz_out == 1'b0, "R5 low after write", buzz_out, 0);
    edges_to(1'b1, h + 4, n);
    chk(n == h, $sformatf("R2 R3 R4 high after sel=%0d match=%0d", sel, match), n, h);
    edges_to(1'b0, h + 4, n);
    chk(n == h, $sformatf("R4 high phase sel=%0d match=%0d", sel, match), n, h);
  endtask

  initial begin
    int n, h, tn, ph;
    // R1: reset state
    repeat (3) @(negedge clk);
    chk(buzz_out == 1'b0, "R1 low in reset", buzz_out, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(buzz_out == 1'b0, "R1 low after reset", buzz_out, 0);
    // R1: cleared word gives prescale 2, match 0: first rise 2 edges after release
    edges_to(1'b1, 10, n);
    chk(n == 1 || n == 2, "R1 cleared word runs fastest tone", n, 2);

    // R7 boundaries and full sweeps
    for (int s = 0; s < 2; s++)
      for (int m = 0; m < 64; m++) sweep_one(s, m);
    for (int s = 2; s < 4; s++) begin
      sweep_one(s, 0);   // R7 fastest for this select
      sweep_one(s, 1);
      sweep_one(s, 31);
      sweep_one(s, 62);
      sweep_one(s, 63);  // R7 slowest for this select
    end

    // R5: restart in the middle of a high phase
    wr_cfg(1, 9);   // half period 40
    h = 40;
    edges_to(1'b1, h + 4, n);
    repeat (7) begin @(posedge clk); @(negedge clk); end
    chk(buzz_out == 1'b1, "R5 high before restart", buzz_out, 1);
    wr_cfg(1, 9);
    chk(buzz_out == 1'b0, "R5 restart drops output", buzz_out, 0);
    edges_to(1'b1, h + 4, n);
    chk(n == h, "R5 restart first rise", n, h);

    // R6: muted output, counting continues
    @(negedge clk);
    out_en = 1'b0;
    wr_cfg(0, 2);   // half period 6
    h = 6;
    tn = 21;
    for (int i = 0; i < tn; i++) begin
      @(posedge clk);
      @(negedge clk);
      chk(buzz_out == 1'b0, "R6 muted output low", buzz_out, 0);
    end
    out_en = 1'b1;
    #1;
    ph = (tn / h) % 2;
    chk(buzz_out == ph, "R6 phase kept while muted", buzz_out, ph);
    edges_to(ph == 1 ? 1'b0 : 1'b1, h + 4, n);
    chk(n == h - (tn % h), "R6 toggle schedule kept", n, h - (tn % h));

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (180000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule